// File: doc/BRIEF.md
# Parity Read-Modify-Write Sequencer

This block carries out a single-block write into a disk array protected by one parity disk per row. A request names the disk that holds the data, the disk that holds parity for that row, and the row. The block then takes a stream of new data words. It reads the old data block and then the old parity block. As the second read comes in, it folds each parity word to old parity XOR old data XOR new data. It then writes the new data block and the new parity block back. All disk traffic goes over one shared command channel that carries a disk index. Read data and write data use valid/ready beats, and each write ends with a response beat.

Only one write is in flight at a time. The request handshake stays closed from acceptance until the one-cycle completion or error pulse. Because the parity disk index comes with each request, the same block serves a fixed parity disk or parity that rotates per row. If any disk reports an error, the sequence stops at once with an error pulse. No further commands are issued, so parity is never written when the failure came before the parity write.

Top module: `rmw_parity_seq`

## Requirements
- R1: After reset the block is idle: `req_ready_o` is 1, and `cmd_valid_o`, `nd_ready_o`, `done_o` and `err_o` are 0.
- R2: Once a request is accepted, `req_ready_o` stays 0 until the cycle after the `done_o` or `err_o` pulse. A request held valid while busy is not taken, and no extra disk command follows.
- R3: After acceptance the block takes exactly NWORDS new data words, in order, before it issues any disk command. It tolerates gaps in `nd_valid_i`.
- R4: A successful write issues exactly four commands, in this order: read of the data disk, read of the parity disk, write of the data disk, write of the parity disk. `cmd_write_o` is 1 for writes, and every command carries the request row.
- R5: No write command is issued until both read commands have been accepted and both read blocks fully received. A command is held stable while `cmd_ready_i` is 0.
- R6: The data block written holds the new data words in arrival order.
- R7: Parity word i written equals old parity word i XOR old data word i XOR new data word i.
- R8: `done_o` is a single-cycle pulse, raised the cycle after the parity write response is accepted without error. It is never high together with `err_o`.
- R9: A read beat with `rd_err_i` = 1 ends the sequence with an `err_o` pulse, and no further command is issued. Both the data block and the parity block stay unchanged.
- R10: An error response to the data write gives `err_o` and no `done_o`, and the parity block is left unwritten.
- R11: The parity disk index is taken from each request, so any disk, including disk 0, may hold parity for a row.
- R12: An error response to the parity write gives an `err_o` pulse and no `done_o`. The block then accepts a new request and completes it normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Write request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_data_disk_i | input | DISK_W | Disk holding the target data block |
| req_par_disk_i | input | DISK_W | Disk holding parity for the row |
| req_row_i | input | ROW_W | Row (block address on each disk) |
| nd_valid_i | input | 1 | New data word valid |
| nd_ready_o | output | 1 | Block takes new data words |
| nd_data_i | input | WORD_W | New data word |
| cmd_valid_o | output | 1 | Disk command valid |
| cmd_ready_i | input | 1 | Disk command accepted |
| cmd_write_o | output | 1 | 1 = write command, 0 = read command |
| cmd_disk_o | output | DISK_W | Target disk of the command |
| cmd_row_o | output | ROW_W | Target row of the command |
| rd_valid_i | input | 1 | Read data beat valid |
| rd_ready_o | output | 1 | Block takes read beats |
| rd_data_i | input | WORD_W | Read data word |
| rd_err_i | input | 1 | Read beat carries an error |
| wd_valid_o | output | 1 | Write data beat valid |
| wd_ready_i | input | 1 | Disk takes write beat |
| wd_data_o | output | WORD_W | Write data word |
| wr_rsp_valid_i | input | 1 | Write response valid |
| wr_rsp_err_i | input | 1 | Write response reports an error |
| done_o | output | 1 | One-cycle pulse: write finished cleanly |
| err_o | output | 1 | One-cycle pulse: sequence aborted |

## Verification
The hardest case to reach from the ports is a failure in the middle of the sequence. An example is a data write that fails after the data disk has already taken new contents, where the bench must show that the parity block is still untouched. The bench drives a behavioural disk model that fails one chosen access by its position in the sequence. It fails the parity read on a late beat, then the data-write response, then the parity-write response. After each failure it reads the model's stored blocks and its command log directly. It also delays command acceptance, leaves gaps in the new-data stream, and holds a second request valid across a whole sequence.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LOAD,
        S_CRD_D,
        S_RD_D,
        S_CRD_P,
        S_RD_P,
        S_CWR_D,
        S_WD_D,
        S_RSP_D,
        S_CWR_P,
        S_WD_P,
        S_RSP_P,
        S_DONE,
        S_FAIL
    } seq_state_e;

    // operation applied to the block buffer at the current word index
    typedef enum logic [1:0] {
        BUF_NONE,
        BUF_LOAD,   // store a new data word
        BUF_SEED,   // parity slot := new word ^ old data word
        BUF_FOLD    // parity slot ^= old parity word
    } buf_op_e;

endpackage

// File: rtl/rmw_beat_ctr.sv
module rmw_beat_ctr #(
    parameter int NBEATS = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      step,
    output logic [$clog2(NBEATS)-1:0] idx,
    output logic                      last
);
    localparam int IW = $clog2(NBEATS);
    localparam logic [IW-1:0] LAST_IDX = IW'(NBEATS - 1);

    logic [IW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (step) begin
            cnt_d = (cnt_q == LAST_IDX) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign idx  = cnt_q;
    assign last = (cnt_q == LAST_IDX);

endmodule

// File: rtl/rmw_blk_buf.sv
module rmw_blk_buf
    import rmw_pkg::*;
#(
    parameter int NWORDS = 8,
    parameter int WORD_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  buf_op_e                   op,
    input  logic [$clog2(NWORDS)-1:0] idx,
    input  logic [WORD_W-1:0]         din,
    output logic [WORD_W-1:0]         new_word,
    output logic [WORD_W-1:0]         par_word
);
    logic [WORD_W-1:0] new_d [NWORDS];
    logic [WORD_W-1:0] new_q [NWORDS];
    logic [WORD_W-1:0] par_d [NWORDS];
    logic [WORD_W-1:0] par_q [NWORDS];

    always_comb begin
        new_d = new_q;
        par_d = par_q;
        unique case (op)
            BUF_LOAD: new_d[idx] = din;
            BUF_SEED: par_d[idx] = new_q[idx] ^ din;
            BUF_FOLD: par_d[idx] = par_q[idx] ^ din;
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORDS; i++) begin
                new_q[i] <= '0;
                par_q[i] <= '0;
            end
        end else begin
            new_q <= new_d;
            par_q <= par_d;
        end
    end

    assign new_word = new_q[idx];
    assign par_word = par_q[idx];

endmodule

// File: rtl/rmw_parity_seq.sv
module rmw_parity_seq
    import rmw_pkg::*;
#(
    parameter int NWORDS = 8,
    parameter int WORD_W = 32,
    parameter int NDISK  = 5,
    parameter int ROW_W  = 16,
    localparam int DISK_W = $clog2(NDISK),
    localparam int IW     = $clog2(NWORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [DISK_W-1:0] req_data_disk_i,
    input  logic [DISK_W-1:0] req_par_disk_i,
    input  logic [ROW_W-1:0]  req_row_i,
    input  logic              nd_valid_i,
    output logic              nd_ready_o,
    input  logic [WORD_W-1:0] nd_data_i,
    output logic              cmd_valid_o,
    input  logic              cmd_ready_i,
    output logic              cmd_write_o,
    output logic [DISK_W-1:0] cmd_disk_o,
    output logic [ROW_W-1:0]  cmd_row_o,
    input  logic              rd_valid_i,
    output logic              rd_ready_o,
    input  logic [WORD_W-1:0] rd_data_i,
    input  logic              rd_err_i,
    output logic              wd_valid_o,
    input  logic              wd_ready_i,
    output logic [WORD_W-1:0] wd_data_o,
    input  logic              wr_rsp_valid_i,
    input  logic              wr_rsp_err_i,
    output logic              done_o,
    output logic              err_o
);
    typedef struct packed {
        seq_state_e        st;
        logic [DISK_W-1:0] dd;
        logic [DISK_W-1:0] pd;
        logic [ROW_W-1:0]  row;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    buf_op_e           buf_op;
    logic              beat_step, beat_clr, beat_last;
    logic [IW-1:0]     beat_idx;
    logic [WORD_W-1:0] buf_din, new_word, par_word;

    rmw_beat_ctr #(.NBEATS(NWORDS)) beat_ctr_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (beat_clr),
        .step (beat_step),
        .idx  (beat_idx),
        .last (beat_last)
    );

    rmw_blk_buf #(.NWORDS(NWORDS), .WORD_W(WORD_W)) blk_buf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (buf_op),
        .idx     (beat_idx),
        .din     (buf_din),
        .new_word(new_word),
        .par_word(par_word)
    );

    always_comb begin
        ctl_d     = ctl_q;
        buf_op    = BUF_NONE;
        buf_din   = rd_data_i;
        beat_step = 1'b0;
        beat_clr  = 1'b0;
        unique case (ctl_q.st)
            S_IDLE: begin
                if (req_valid_i) begin
                    ctl_d.st  = S_LOAD;
                    ctl_d.dd  = req_data_disk_i;
                    ctl_d.pd  = req_par_disk_i;
                    ctl_d.row = req_row_i;
                    beat_clr  = 1'b1;
                end
            end
            S_LOAD: begin
                buf_din = nd_data_i;
                if (nd_valid_i) begin
                    buf_op    = BUF_LOAD;
                    beat_step = 1'b1;
                    if (beat_last) ctl_d.st = S_CRD_D;
                end
            end
            S_CRD_D: if (cmd_ready_i) ctl_d.st = S_RD_D;
            S_RD_D: begin
                if (rd_valid_i) begin
                    if (rd_err_i) begin
                        ctl_d.st = S_FAIL;
                    end else begin
                        buf_op    = BUF_SEED;
                        beat_step = 1'b1;
                        if (beat_last) ctl_d.st = S_CRD_P;
                    end
                end
            end
            S_CRD_P: if (cmd_ready_i) ctl_d.st = S_RD_P;
            S_RD_P: begin
                if (rd_valid_i) begin
                    if (rd_err_i) begin
                        ctl_d.st = S_FAIL;
                    end else begin
                        buf_op    = BUF_FOLD;
                        beat_step = 1'b1;
                        if (beat_last) ctl_d.st = S_CWR_D;
                    end
                end
            end
            S_CWR_D: if (cmd_ready_i) ctl_d.st = S_WD_D;
            S_WD_D: begin
                if (wd_ready_i) begin
                    beat_step = 1'b1;
                    if (beat_last) ctl_d.st = S_RSP_D;
                end
            end
            S_RSP_D: if (wr_rsp_valid_i) ctl_d.st = wr_rsp_err_i ? S_FAIL : S_CWR_P;
            S_CWR_P: if (cmd_ready_i) ctl_d.st = S_WD_P;
            S_WD_P: begin
                if (wd_ready_i) begin
                    beat_step = 1'b1;
                    if (beat_last) ctl_d.st = S_RSP_P;
                end
            end
            S_RSP_P: if (wr_rsp_valid_i) ctl_d.st = wr_rsp_err_i ? S_FAIL : S_DONE;
            default: ctl_d.st = S_IDLE;   // S_DONE, S_FAIL
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: S_IDLE, dd: '0, pd: '0, row: '0};
        else        ctl_q <= ctl_d;
    end

    assign req_ready_o = (ctl_q.st == S_IDLE);
    assign nd_ready_o  = (ctl_q.st == S_LOAD);
    assign cmd_valid_o = (ctl_q.st == S_CRD_D) || (ctl_q.st == S_CRD_P) ||
                         (ctl_q.st == S_CWR_D) || (ctl_q.st == S_CWR_P);
    assign cmd_write_o = (ctl_q.st == S_CWR_D) || (ctl_q.st == S_CWR_P);
    assign cmd_disk_o  = ((ctl_q.st == S_CRD_D) || (ctl_q.st == S_CWR_D)) ? ctl_q.dd : ctl_q.pd;
    assign cmd_row_o   = ctl_q.row;
    assign rd_ready_o  = (ctl_q.st == S_RD_D) || (ctl_q.st == S_RD_P);
    assign wd_valid_o  = (ctl_q.st == S_WD_D) || (ctl_q.st == S_WD_P);
    assign wd_data_o   = (ctl_q.st == S_WD_D) ? new_word : par_word;
    assign done_o      = (ctl_q.st == S_DONE);
    assign err_o       = (ctl_q.st == S_FAIL);

    // reads accepted since the last request was taken (checking aid)
    logic [1:0] rd_cmds_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                          rd_cmds_q <= '0;
        else if (req_valid_i && req_ready_o)                 rd_cmds_q <= '0;
        else if (cmd_valid_o && cmd_ready_i && !cmd_write_o) rd_cmds_q <= rd_cmds_q + 1'b1;
    end

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> !req_ready_o);

    // R5
    writes_after_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_write_o) |-> (rd_cmds_q == 2'd2 && !rd_ready_o));

    // R5
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_ready_i) |=>
            (cmd_valid_o && $stable(cmd_write_o) && $stable(cmd_disk_o) && $stable(cmd_row_o)));

    // R8
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !err_o);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && req_ready_o));

    // R9
    halt_after_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> (!cmd_valid_o && !wd_valid_o));

endmodule

// File: tb/rmw_parity_seq_tb.sv
`timescale 1ns/1ps
module rmw_parity_seq_tb_top;
    localparam int NW = 8;
    localparam int WW = 32;
    localparam int ND = 5;
    localparam int RW = 16;
    localparam int DW = $clog2(ND);
    localparam int NROWS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          req_valid = 0, req_ready;
    logic [DW-1:0] req_dd = 0, req_pd = 0;
    logic [RW-1:0] req_row = 0;
    logic          nd_valid = 0, nd_ready;
    logic [WW-1:0] nd_data = 0;
    logic          cmd_valid, cmd_ready = 0, cmd_write;
    logic [DW-1:0] cmd_disk;
    logic [RW-1:0] cmd_row;
    logic          rd_valid = 0, rd_ready, rd_err = 0;
    logic [WW-1:0] rd_data = 0;
    logic          wd_valid, wd_ready = 0;
    logic [WW-1:0] wd_data;
    logic          wr_rsp_valid = 0, wr_rsp_err = 0;
    logic          done, err;

    rmw_parity_seq #(.NWORDS(NW), .WORD_W(WW), .NDISK(ND), .ROW_W(RW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_data_disk_i(req_dd), .req_par_disk_i(req_pd), .req_row_i(req_row),
        .nd_valid_i(nd_valid), .nd_ready_o(nd_ready), .nd_data_i(nd_data),
        .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_write_o(cmd_write),
        .cmd_disk_o(cmd_disk), .cmd_row_o(cmd_row),
        .rd_valid_i(rd_valid), .rd_ready_o(rd_ready), .rd_data_i(rd_data), .rd_err_i(rd_err),
        .wd_valid_o(wd_valid), .wd_ready_i(wd_ready), .wd_data_o(wd_data),
        .wr_rsp_valid_i(wr_rsp_valid), .wr_rsp_err_i(wr_rsp_err),
        .done_o(done), .err_o(err)
    );

    int checks = 0;
    int fails  = 0;

    // behavioural disk array
    logic [WW-1:0] mem [ND][NROWS][NW];
    int n_acc = 0;
    int log_w [8];
    int log_d [8];
    int log_r [8];
    int inj_acc = -1;
    int cmd_delay = 0;

    logic [WW-1:0] nw      [NW];
    logic [WW-1:0] exp_par [NW];
    logic [WW-1:0] old_d   [NW];
    logic [WW-1:0] old_p   [NW];

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    // disk model process
    initial begin
        forever begin
            @(negedge clk);
            if (cmd_valid) begin
                int a, cnt;
                bit w;
                int d, r;
                repeat (cmd_delay) @(negedge clk);
                cmd_ready = 1;
                w = cmd_write; d = int'(cmd_disk); r = int'(cmd_row);
                a = n_acc;
                if (a < 8) begin log_w[a] = w; log_d[a] = d; log_r[a] = r; end
                n_acc++;
                @(negedge clk);
                cmd_ready = 0;
                if (!w) begin
                    for (int i = 0; i < NW; i++) begin
                        rd_valid = 1;
                        rd_data  = mem[d][r % NROWS][i];
                        rd_err   = (a == inj_acc) && (i == 5);
                        @(negedge clk);
                    end
                    rd_valid = 0; rd_err = 0;
                end else begin
                    cnt = 0;
                    wd_ready = 1;
                    while (cnt < NW) begin
                        if (wd_valid) begin
                            mem[d][r % NROWS][cnt] = wd_data;
                            cnt++;
                        end
                        @(negedge clk);
                    end
                    wd_ready = 0;
                    wr_rsp_valid = 1;
                    wr_rsp_err = (a == inj_acc);
                    @(negedge clk);
                    wr_rsp_valid = 0; wr_rsp_err = 0;
                end
            end
        end
    end

    task automatic init_mem();
        for (int d = 0; d < ND; d++)
            for (int r = 0; r < NROWS; r++)
                for (int i = 0; i < NW; i++)
                    mem[d][r][i] = 32'hA500_0000 ^ (d << 16) ^ (r << 8) ^ (i * 37);
    endtask

    // issue one write; returns number of done cycles and err seen
    task automatic run_write(input int dd, input int pd, input int row, input int seed,
                             input bit gaps, input bit hold_req,
                             output int done_cycles, output bit err_seen);
        int wait_n;
        for (int i = 0; i < NW; i++) begin
            nw[i]      = 32'h1357_9BDF * (seed + i + 1) ^ (i << 24);
            old_d[i]   = mem[dd][row][i];
            old_p[i]   = mem[pd][row][i];
            exp_par[i] = old_p[i] ^ old_d[i] ^ nw[i];
        end
        n_acc = 0;
        done_cycles = 0; err_seen = 0;
        @(negedge clk);
        req_valid = 1; req_dd = DW'(dd); req_pd = DW'(pd); req_row = RW'(row);
        @(negedge clk);
        req_valid = hold_req;
        req_dd = DW'((dd + 1) % ND);
        chk(req_ready == 0, "R2 ready low after accept", req_ready, 0);
        for (int i = 0; i < NW; i++) begin
            if (gaps && (i % 2 == 1)) begin
                nd_valid = 0;
                @(negedge clk);
                chk(cmd_valid == 0, "R3 no command during load", cmd_valid, 0);
            end
            nd_valid = 1; nd_data = nw[i];
            @(negedge clk);
        end
        nd_valid = 0;
        wait_n = 0;
        while (!done && !err && wait_n < 2000) begin
            if (hold_req) chk(req_ready == 0, "R2 ready low while busy", req_ready, 0);
            @(negedge clk);
            wait_n++;
        end
        req_valid = 0;
        for (int k = 0; k < 4; k++) begin
            if (done) done_cycles++;
            if (err)  err_seen = 1;
            @(negedge clk);
        end
        repeat (20) @(negedge clk);
    endtask

    task automatic check_success(input int dd, input int pd, input int row, input string tag,
                                 input int done_cycles, input bit err_seen);
        chk(done_cycles == 1, {tag, " R8 single done pulse"}, done_cycles, 1);
        chk(err_seen == 0, {tag, " R8 no err"}, err_seen, 0);
        chk(n_acc == 4, {tag, " R4 four accesses"}, n_acc, 4);
        chk(log_w[0] == 0 && log_d[0] == dd, {tag, " R4 first is data read"}, log_d[0], dd);
        chk(log_w[1] == 0 && log_d[1] == pd, {tag, " R4 second is parity read"}, log_d[1], pd);
        chk(log_w[2] == 1 && log_d[2] == dd, {tag, " R5 third is data write"}, log_d[2], dd);
        chk(log_w[3] == 1 && log_d[3] == pd, {tag, " R4 fourth is parity write"}, log_d[3], pd);
        chk(log_r[0] == row && log_r[3] == row, {tag, " R4 row carried"}, log_r[3], row);
        for (int i = 0; i < NW; i++) begin
            chk(mem[dd][row][i] == nw[i], {tag, " R6 data word"}, mem[dd][row][i], nw[i]);
            chk(mem[pd][row][i] == exp_par[i], {tag, " R7 parity word"}, mem[pd][row][i], exp_par[i]);
        end
    endtask

    task automatic t_reset();
        chk(req_ready == 1, "R1 req_ready", req_ready, 1);
        chk(cmd_valid == 0, "R1 cmd_valid", cmd_valid, 0);
        chk(nd_ready == 0, "R1 nd_ready", nd_ready, 0);
        chk(done == 0 && err == 0, "R1 done/err", {done, err}, 0);
    endtask

    task automatic t_basic();
        int dc; bit es;
        run_write(1, 4, 2, 3, 0, 0, dc, es);
        check_success(1, 4, 2, "basic", dc, es);
    endtask

    task automatic t_rotating();
        int dc; bit es;
        cmd_delay = 3;
        run_write(3, 0, 1, 11, 1, 0, dc, es);
        check_success(3, 0, 1, "R11 rotating", dc, es);
        run_write(2, 0, 1, 19, 0, 0, dc, es);
        check_success(2, 0, 1, "R11 same row again", dc, es);
        cmd_delay = 0;
    endtask

    task automatic t_busy();
        int dc; bit es;
        run_write(0, 2, 3, 5, 0, 1, dc, es);
        check_success(0, 2, 3, "R2 busy", dc, es);
        chk(n_acc == 4, "R2 held request not taken", n_acc, 4);
    endtask

    task automatic t_read_err();
        int dc; bit es; bit same;
        inj_acc = 1;
        run_write(2, 3, 0, 7, 0, 0, dc, es);
        inj_acc = -1;
        chk(es == 1 && dc == 0, "R9 err on parity read", {es, dc[0]}, 2);
        chk(n_acc == 2, "R9 no command after read error", n_acc, 2);
        same = 1;
        for (int i = 0; i < NW; i++)
            if (mem[2][0][i] != old_d[i] || mem[3][0][i] != old_p[i]) same = 0;
        chk(same, "R9 blocks unchanged", same, 1);
    endtask

    task automatic t_data_wr_err();
        int dc; bit es; bit same;
        inj_acc = 2;
        run_write(4, 1, 2, 9, 0, 0, dc, es);
        inj_acc = -1;
        chk(es == 1 && dc == 0, "R10 err on data write", {es, dc[0]}, 2);
        chk(n_acc == 3, "R10 parity write not issued", n_acc, 3);
        same = 1;
        for (int i = 0; i < NW; i++) if (mem[1][2][i] != old_p[i]) same = 0;
        chk(same, "R10 parity unchanged", same, 1);
    endtask

    task automatic t_par_wr_err();
        int dc; bit es;
        inj_acc = 3;
        run_write(1, 3, 3, 13, 0, 0, dc, es);
        inj_acc = -1;
        chk(es == 1 && dc == 0, "R12 err on parity write", {es, dc[0]}, 2);
        chk(n_acc == 4, "R12 four accesses", n_acc, 4);
        chk(req_ready == 1, "R12 idle after error", req_ready, 1);
        run_write(1, 3, 3, 21, 1, 0, dc, es);
        check_success(1, 3, 3, "R12 recovery", dc, es);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        init_mem();
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_rotating();
        t_busy();
        t_read_err();
        t_data_wr_err();
        t_par_wr_err();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule